// File: doc/BRIEF.md
# ATA Channel Reset and Probe Sequencer

This block brings up one ATA-style channel after power-on. It drives the channel's task-file registers through a simple synchronous register port and finds out which of the two device positions is occupied. For each position it selects the device and writes an alternating bit pattern into two scratch registers. It then reads the pattern back, and a correct readback marks the position as occupied.

When at least one position answers, the sequencer selects device 0 and pulses the software-reset bit in the control register. It lets the channel settle and then polls the status register until the busy bit clears. Polling runs in budgeted rounds with longer pauses between rounds. If busy is still set when the last round ends, the run fails. A controller that owns the channel pulses `start_i`, waits for `done_o`, and then reads the two-bit device mask and the failure flag.

Every delay and every poll count is a parameter in clock cycles. The register port uses `reg_ctl_sel_o` to choose the control/alternate-status register. When that select is low, `reg_addr_o` picks one command-block register: 2 = sector count, 3 = LBA low, 6 = device/head, 7 = status. Read data is taken in the same cycle as the read strobe.

Top module: `ata_chan_bringup`

## Requirements
- R1: After reset, `done_o`, `fail_o`, `dev_mask_o`, `reg_wr_o` and `reg_rd_o` are all 0, and no register access happens until `start_i` is seen.
- R2: To select device d, the block writes 0xA0 | (d << 4) to address 6 with `reg_ctl_sel_o`=0. It then does one read with `reg_ctl_sel_o`=1 and leaves at least `SEL_SETTLE` idle cycles before the next access.
- R3: After selecting device d, the block makes six writes in this order: addr 2 ← 0x55, addr 3 ← 0xAA, addr 2 ← 0xAA, addr 3 ← 0x55, addr 2 ← 0x55, addr 3 ← 0xAA. It then reads addr 2 and then addr 3. Device 0 is probed before device 1.
- R4: Device d counts as present only if addr 2 reads back 0x55 and addr 3 reads back 0xAA. A present device sets bit d of `dev_mask_o`.
- R5: If neither device is present, there are no control writes and no status reads. The block raises `done_o` with `fail_o`=1 and a mask of 0.
- R6: When the mask is non-zero, the block selects device 0 (the R2 sequence with d=0). It then writes the control register (`reg_ctl_sel_o`=1) with 0x08, 0x0C and 0x08, leaving at least `SRST_HOLD` idle cycles after each of the first two writes.
- R7: The first status read (addr 7, `reg_ctl_sel_o`=0) comes at least `SETTLE_CYC` idle cycles after the final 0x08 control write.
- R8: Status reads are separated by at least `POLL_IVL` idle cycles. The first read with bit 7 (0x80) clear ends the run with `fail_o`=0.
- R9: The first round allows `FIRST_POLLS` reads. After a round ends with busy still set, the block waits at least `RETRY_GAP` idle cycles and starts a new round of `RETRY_POLLS` reads.
- R10: After `MAX_RETRIES` retry rounds, if busy is still set on the last read, the run ends with `fail_o`=1. The total number of status reads is then `FIRST_POLLS + MAX_RETRIES*RETRY_POLLS`.
- R11: A `start_i` pulse that arrives while a sequence is running has no effect: there is no extra access sequence and no extra `done_o`.
- R12: `done_o` is a single-cycle pulse. `dev_mask_o` and `fail_o` keep their values from the end of a run until the next accepted start.
- R13: `reg_wr_o` and `reg_rd_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the probe and reset sequence (used only when idle) |
| reg_addr_o | output | 3 | Command-block register index |
| reg_ctl_sel_o | output | 1 | 1 selects the control/alternate-status register |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, valid in the read-strobe cycle |
| dev_mask_o | output | 2 | Bit d set when device d answered the probe |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Run ended with no device or with busy stuck |

## Verification
The bench records every register access with its cycle number. It runs with one device present, with both present and with none, and it holds busy for a set number of status reads. One case has busy clearing inside a retry round and another has busy never clearing.

- A design that confused the two halves of the pattern, or tested only one register, would report an empty position as present, or a present one as empty.
- A design that ran the reset with a zero mask would show control writes in the log.
- A design that lost count of the round budget would end with the wrong number of status reads.
- A design that skipped the inter-round pause would show a too-short gap at the round boundary.
- A second start pulse sent during a run would trigger a second access sequence in a design that failed to ignore it.

// File: rtl/ata_bringup_pkg.sv
package ata_bringup_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SEL_WR,
    S_SEL_RD,
    S_SEL_WAIT,
    S_PAT_WR,
    S_CHK_NS,
    S_CHK_LB,
    S_NEXT_DEV,
    S_CTL_WR,
    S_CTL_WAIT,
    S_SETTLE,
    S_POLL_WAIT,
    S_POLL_RD,
    S_GAP,
    S_FINISH
  } seq_state_e;

  localparam logic [2:0] RA_NSECT = 3'd2;
  localparam logic [2:0] RA_LBAL  = 3'd3;
  localparam logic [2:0] RA_DEVHD = 3'd6;
  localparam logic [2:0] RA_STAT  = 3'd7;

  localparam logic [7:0] DEVHD_BASE = 8'hA0;
  localparam logic [7:0] CTL_QUIET  = 8'h08;
  localparam logic [7:0] CTL_SRST   = 8'h04;
  localparam logic [7:0] PAT_LO     = 8'h55;
  localparam logic [7:0] PAT_HI     = 8'hAA;

  localparam int STAT_BSY_BIT = 7;
  localparam logic [2:0] PAT_LAST = 3'd5;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Even steps hit sector count, odd steps hit LBA low; steps 2 and 3 swap values.
  function automatic logic [2:0] pat_addr(input logic [2:0] idx);
    return idx[0] ? RA_LBAL : RA_NSECT;
  endfunction

  function automatic logic [7:0] pat_data(input logic [2:0] idx);
    logic swap;
    swap = (idx == 3'd2) || (idx == 3'd3);
    return (idx[0] ^ swap) ? PAT_HI : PAT_LO;
  endfunction

endpackage

// File: rtl/ata_rst_sync.sv
module ata_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/ata_down_ctr.sv
module ata_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (dec_i && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (cnt_en) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ata_chan_bringup.sv
module ata_chan_bringup
  import ata_bringup_pkg::*;
#(
  parameter int SEL_SETTLE  = 500,
  parameter int SRST_HOLD   = 1000,
  parameter int SETTLE_CYC  = 15000000,
  parameter int POLL_IVL    = 100000,
  parameter int FIRST_POLLS = 300,
  parameter int RETRY_POLLS = 3,
  parameter int RETRY_GAP   = 10000000,
  parameter int MAX_RETRIES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic [2:0] reg_addr_o,
  output logic       reg_ctl_sel_o,
  output logic       reg_wr_o,
  output logic       reg_rd_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i,
  output logic [1:0] dev_mask_o,
  output logic       done_o,
  output logic       fail_o
);

  localparam int DLY_MAX = imax(imax(imax(SEL_SETTLE, SRST_HOLD), imax(SETTLE_CYC, POLL_IVL)),
                                RETRY_GAP);
  localparam int TMR_W   = $clog2(DLY_MAX + 2);
  localparam int POL_W   = $clog2(imax(FIRST_POLLS, RETRY_POLLS) + 2);
  localparam int RND_W   = $clog2(MAX_RETRIES + 2);

  logic rst_n_s;

  seq_state_e state_q, state_d;
  logic       dev_q, dev_d;
  logic       rst_ph_q, rst_ph_d;
  logic [2:0] idx_q, idx_d;
  logic [1:0] mask_q, mask_d;
  logic       nsok_q, nsok_d;
  logic       fail_q, fail_d;

  logic             tmr_ld, tmr_zero;
  logic [TMR_W-1:0] tmr_val, tmr_cnt;
  logic             pol_ld, pol_dec, pol_zero;
  logic [POL_W-1:0] pol_val, pol_cnt;
  logic             rnd_ld, rnd_dec, rnd_zero;
  logic [RND_W-1:0] rnd_cnt;

  ata_rst_sync u_rst_sync (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  ata_down_ctr #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load_i(tmr_ld), .load_val_i(tmr_val),
    .dec_i(1'b1), .cnt_o(tmr_cnt), .zero_o(tmr_zero)
  );

  ata_down_ctr #(.W(POL_W)) u_pol (
    .clk(clk), .rst_n(rst_n_s), .load_i(pol_ld), .load_val_i(pol_val),
    .dec_i(pol_dec), .cnt_o(pol_cnt), .zero_o(pol_zero)
  );

  ata_down_ctr #(.W(RND_W)) u_rnd (
    .clk(clk), .rst_n(rst_n_s), .load_i(rnd_ld), .load_val_i(RND_W'(MAX_RETRIES)),
    .dec_i(rnd_dec), .cnt_o(rnd_cnt), .zero_o(rnd_zero)
  );

  always_comb begin
    state_d  = state_q;
    dev_d    = dev_q;
    rst_ph_d = rst_ph_q;
    idx_d    = idx_q;
    mask_d   = mask_q;
    nsok_d   = nsok_q;
    fail_d   = fail_q;

    reg_addr_o    = 3'd0;
    reg_ctl_sel_o = 1'b0;
    reg_wr_o      = 1'b0;
    reg_rd_o      = 1'b0;
    reg_wdata_o   = 8'h00;

    tmr_ld  = 1'b0;
    tmr_val = '0;
    pol_ld  = 1'b0;
    pol_val = '0;
    pol_dec = 1'b0;
    rnd_ld  = 1'b0;
    rnd_dec = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          mask_d   = 2'b00;
          fail_d   = 1'b0;
          dev_d    = 1'b0;
          rst_ph_d = 1'b0;
          state_d  = S_SEL_WR;
        end
      end
      S_SEL_WR: begin
        reg_wr_o    = 1'b1;
        reg_addr_o  = RA_DEVHD;
        reg_wdata_o = DEVHD_BASE | {3'b000, dev_q, 4'b0000};
        state_d     = S_SEL_RD;
      end
      S_SEL_RD: begin
        reg_rd_o      = 1'b1;
        reg_ctl_sel_o = 1'b1;
        tmr_ld        = 1'b1;
        tmr_val       = TMR_W'(SEL_SETTLE);
        idx_d         = 3'd0;
        state_d       = S_SEL_WAIT;
      end
      S_SEL_WAIT: begin
        if (tmr_zero) state_d = rst_ph_q ? S_CTL_WR : S_PAT_WR;
      end
      S_PAT_WR: begin
        reg_wr_o    = 1'b1;
        reg_addr_o  = pat_addr(idx_q);
        reg_wdata_o = pat_data(idx_q);
        if (idx_q == PAT_LAST) state_d = S_CHK_NS;
        else                   idx_d   = idx_q + 3'd1;
      end
      S_CHK_NS: begin
        reg_rd_o   = 1'b1;
        reg_addr_o = RA_NSECT;
        nsok_d     = (reg_rdata_i == PAT_LO);
        state_d    = S_CHK_LB;
      end
      S_CHK_LB: begin
        reg_rd_o   = 1'b1;
        reg_addr_o = RA_LBAL;
        if (nsok_q && (reg_rdata_i == PAT_HI)) mask_d = mask_q | (2'b01 << dev_q);
        state_d    = S_NEXT_DEV;
      end
      S_NEXT_DEV: begin
        if (!dev_q) begin
          dev_d   = 1'b1;
          state_d = S_SEL_WR;
        end else if (mask_q == 2'b00) begin
          fail_d  = 1'b1;
          state_d = S_FINISH;
        end else begin
          dev_d    = 1'b0;
          rst_ph_d = 1'b1;
          state_d  = S_SEL_WR;
        end
      end
      S_CTL_WR: begin
        reg_wr_o      = 1'b1;
        reg_ctl_sel_o = 1'b1;
        reg_wdata_o   = (idx_q == 3'd1) ? (CTL_QUIET | CTL_SRST) : CTL_QUIET;
        tmr_ld        = 1'b1;
        if (idx_q == 3'd2) begin
          tmr_val = TMR_W'(SETTLE_CYC);
          pol_ld  = 1'b1;
          pol_val = POL_W'(FIRST_POLLS);
          rnd_ld  = 1'b1;
          state_d = S_SETTLE;
        end else begin
          tmr_val = TMR_W'(SRST_HOLD);
          idx_d   = idx_q + 3'd1;
          state_d = S_CTL_WAIT;
        end
      end
      S_CTL_WAIT: begin
        if (tmr_zero) state_d = S_CTL_WR;
      end
      S_SETTLE: begin
        if (tmr_zero) begin
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(POLL_IVL);
          state_d = S_POLL_WAIT;
        end
      end
      S_POLL_WAIT: begin
        if (tmr_zero) state_d = S_POLL_RD;
      end
      S_POLL_RD: begin
        reg_rd_o   = 1'b1;
        reg_addr_o = RA_STAT;
        if (!reg_rdata_i[STAT_BSY_BIT]) begin
          state_d = S_FINISH;
        end else if (pol_zero || (pol_cnt == POL_W'(1))) begin
          if (rnd_zero) begin
            fail_d  = 1'b1;
            state_d = S_FINISH;
          end else begin
            rnd_dec = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = TMR_W'(RETRY_GAP);
            state_d = S_GAP;
          end
        end else begin
          pol_dec = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(POLL_IVL);
          state_d = S_POLL_WAIT;
        end
      end
      S_GAP: begin
        if (tmr_zero) begin
          pol_ld  = 1'b1;
          pol_val = POL_W'(RETRY_POLLS);
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(POLL_IVL);
          state_d = S_POLL_WAIT;
        end
      end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= S_IDLE;
      dev_q    <= 1'b0;
      rst_ph_q <= 1'b0;
      idx_q    <= 3'd0;
      mask_q   <= 2'b00;
      nsok_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      dev_q    <= dev_d;
      rst_ph_q <= rst_ph_d;
      idx_q    <= idx_d;
      mask_q   <= mask_d;
      nsok_q   <= nsok_d;
      fail_q   <= fail_d;
    end
  end

  assign dev_mask_o = mask_q;
  assign fail_o     = fail_q;
  assign done_o     = (state_q == S_FINISH);

  logic unused_rnd;
  assign unused_rnd = ^rnd_cnt ^ ^tmr_cnt;

endmodule

// File: rtl/ata_chan_bringup_chk.sv
module ata_chan_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr_o,
  input logic       reg_ctl_sel_o,
  input logic       reg_wr_o,
  input logic       reg_rd_o,
  input logic [7:0] reg_wdata_o,
  input logic [1:0] dev_mask_o,
  input logic       done_o,
  input logic       fail_o
);

  // R13
  a_r13_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  // R12
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  a_r5_empty_mask_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (dev_mask_o == 2'b00)) |-> fail_o);

  // R6
  a_r6_ctl_values: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && reg_ctl_sel_o) |-> ((reg_wdata_o == 8'h08) || (reg_wdata_o == 8'h0C)));

  // R2
  a_r2_devsel_value: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && !reg_ctl_sel_o && (reg_addr_o == 3'd6)) |-> ((reg_wdata_o & 8'hEF) == 8'hA0));

  // R12: the failure flag only rises together with the end-of-run pulse
  a_r12_fail_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> done_o);

endmodule

bind ata_chan_bringup ata_chan_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr_o(reg_addr_o), .reg_ctl_sel_o(reg_ctl_sel_o),
  .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_wdata_o(reg_wdata_o),
  .dev_mask_o(dev_mask_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/ata_chan_bringup_tb.sv
module ata_chan_bringup_tb;

  localparam int SEL_SETTLE  = 3;
  localparam int SRST_HOLD   = 5;
  localparam int SETTLE_CYC  = 20;
  localparam int POLL_IVL    = 4;
  localparam int FIRST_POLLS = 6;
  localparam int RETRY_POLLS = 2;
  localparam int RETRY_GAP   = 10;
  localparam int MAX_RETRIES = 2;
  localparam int LOG_N       = 256;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [2:0] reg_addr_o;
  logic       reg_ctl_sel_o;
  logic       reg_wr_o;
  logic       reg_rd_o;
  logic [7:0] reg_wdata_o;
  logic [7:0] reg_rdata_i;
  logic [1:0] dev_mask_o;
  logic       done_o;
  logic       fail_o;

  ata_chan_bringup #(
    .SEL_SETTLE(SEL_SETTLE), .SRST_HOLD(SRST_HOLD), .SETTLE_CYC(SETTLE_CYC),
    .POLL_IVL(POLL_IVL), .FIRST_POLLS(FIRST_POLLS), .RETRY_POLLS(RETRY_POLLS),
    .RETRY_GAP(RETRY_GAP), .MAX_RETRIES(MAX_RETRIES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_addr_o(reg_addr_o),
    .reg_ctl_sel_o(reg_ctl_sel_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i), .dev_mask_o(dev_mask_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // device model
  logic [1:0] pres;
  int         busy_init;
  int         busy_seen;
  logic       cur_dev;
  logic [7:0] ns_reg [2];
  logic [7:0] lb_reg [2];
  logic [7:0] stat_val;

  assign stat_val = (busy_seen < busy_init) ? 8'h80 : 8'h50;

  always_comb begin
    if (reg_ctl_sel_o) reg_rdata_i = stat_val;
    else begin
      case (reg_addr_o)
        3'd2:    reg_rdata_i = pres[cur_dev] ? ns_reg[cur_dev] : 8'hFF;
        3'd3:    reg_rdata_i = pres[cur_dev] ? lb_reg[cur_dev] : 8'hFF;
        3'd7:    reg_rdata_i = stat_val;
        default: reg_rdata_i = 8'h00;
      endcase
    end
  end

  always @(posedge clk) begin
    if (start_i) busy_seen <= 0;
    if (reg_wr_o && !reg_ctl_sel_o) begin
      if (reg_addr_o == 3'd6) cur_dev <= reg_wdata_o[4];
      if (reg_addr_o == 3'd2 && pres[cur_dev]) ns_reg[cur_dev] <= reg_wdata_o;
      if (reg_addr_o == 3'd3 && pres[cur_dev]) lb_reg[cur_dev] <= reg_wdata_o;
    end
    if (reg_rd_o && !reg_ctl_sel_o && reg_addr_o == 3'd7 && !start_i) busy_seen <= busy_seen + 1;
  end

  // access log
  int         cyc = 0;
  int         lg_n = 0;
  int         lg_cyc  [LOG_N];
  logic       lg_wr   [LOG_N];
  logic       lg_sel  [LOG_N];
  logic [2:0] lg_addr [LOG_N];
  logic [7:0] lg_data [LOG_N];
  int         done_cnt = 0;
  int         rw_clash = 0;
  int         done_wide = 0;
  logic       done_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (reg_wr_o && reg_rd_o) rw_clash++;
      if ((reg_wr_o || reg_rd_o) && lg_n < LOG_N) begin
        lg_cyc[lg_n]  = cyc;
        lg_wr[lg_n]   = reg_wr_o;
        lg_sel[lg_n]  = reg_ctl_sel_o;
        lg_addr[lg_n] = reg_addr_o;
        lg_data[lg_n] = reg_wr_o ? reg_wdata_o : reg_rdata_i;
        lg_n++;
      end
      if (done_o) done_cnt++;
      if (done_o && done_prev) done_wide++;
      done_prev = done_o;
    end
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // helpers
  task automatic exp_acc(input int i, input bit wr, input bit sel, input int addr,
                         input int data, input string req);
    bit ok;
    ok = (i < lg_n) && (lg_wr[i] == wr) && (lg_sel[i] == sel);
    if (ok && !sel) ok = (lg_addr[i] == 3'(addr));
    if (ok && wr)   ok = (lg_data[i] == 8'(data));
    chk(ok, req, (i < lg_n) ? int'({lg_wr[i], lg_sel[i], lg_addr[i], lg_data[i]}) : -1,
        int'({wr, sel, 3'(addr), 8'(data)}));
  endtask

  function automatic int idle_between(input int a, input int b);
    return lg_cyc[b] - lg_cyc[a] - 1;
  endfunction

  function automatic int stat_reads();
    int n = 0;
    for (int i = 0; i < lg_n; i++)
      if (!lg_wr[i] && !lg_sel[i] && lg_addr[i] == 3'd7) n++;
    return n;
  endfunction

  task automatic run_seq(input logic [1:0] p, input int nbusy, input int extra_start_at);
    pres      = p;
    busy_init = nbusy;
    @(negedge clk);
    lg_n = 0;
    done_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3000 && done_cnt == 0; k++) begin
      if (k == extra_start_at) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(done_cnt == 1, "R12 run completes", done_cnt, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_probe(input int base, input int d);
    exp_acc(base, 1, 0, 6, 8'hA0 | (d << 4), "R2 device select write");
    exp_acc(base + 1, 0, 1, 0, 0, "R2 alt status read");
    chk(idle_between(base + 1, base + 2) >= SEL_SETTLE, "R2 select settle",
        idle_between(base + 1, base + 2), SEL_SETTLE);
    exp_acc(base + 2, 1, 0, 2, 8'h55, "R3 pattern step 0");
    exp_acc(base + 3, 1, 0, 3, 8'hAA, "R3 pattern step 1");
    exp_acc(base + 4, 1, 0, 2, 8'hAA, "R3 pattern step 2");
    exp_acc(base + 5, 1, 0, 3, 8'h55, "R3 pattern step 3");
    exp_acc(base + 6, 1, 0, 2, 8'h55, "R3 pattern step 4");
    exp_acc(base + 7, 1, 0, 3, 8'hAA, "R3 pattern step 5");
    exp_acc(base + 8, 0, 0, 2, 0, "R3 readback sector count");
    exp_acc(base + 9, 0, 0, 3, 0, "R3 readback LBA low");
  endtask

  task automatic chk_reset_part();
    exp_acc(20, 1, 0, 6, 8'hA0, "R6 select device 0");
    exp_acc(21, 0, 1, 0, 0, "R6 alt status read");
    exp_acc(22, 1, 1, 0, 8'h08, "R6 control quiet");
    exp_acc(23, 1, 1, 0, 8'h0C, "R6 control reset");
    exp_acc(24, 1, 1, 0, 8'h08, "R6 control release");
    chk(idle_between(22, 23) >= SRST_HOLD, "R6 hold 1", idle_between(22, 23), SRST_HOLD);
    chk(idle_between(23, 24) >= SRST_HOLD, "R6 hold 2", idle_between(23, 24), SRST_HOLD);
    exp_acc(25, 0, 0, 7, 0, "R7 first status read");
    chk(idle_between(24, 25) >= SETTLE_CYC, "R7 settle", idle_between(24, 25), SETTLE_CYC);
  endtask

  // scenarios
  task automatic t_reset_state();
    chk(!done_o && !fail_o && dev_mask_o == 2'b00, "R1 outputs after reset",
        int'({done_o, fail_o, dev_mask_o}), 0);
    repeat (10) @(negedge clk);
    chk(lg_n == 0, "R1 no access while idle", lg_n, 0);
  endtask

  task automatic t_both_present();
    run_seq(2'b11, 3, -1);
    chk(dev_mask_o == 2'b11, "R4 both present mask", dev_mask_o, 3);
    chk(!fail_o, "R8 success flag", fail_o, 0);
    chk_probe(0, 0);
    chk_probe(10, 1);
    chk_reset_part();
    chk(stat_reads() == 4, "R8 status reads stop at ready", stat_reads(), 4);
    chk(lg_n == 29, "R8 no access after ready", lg_n, 29);
    for (int i = 25; i < 28; i++)
      chk(idle_between(i, i + 1) >= POLL_IVL, "R8 poll interval", idle_between(i, i + 1), POLL_IVL);
  endtask

  task automatic t_dev1_only();
    run_seq(2'b10, 0, -1);
    chk(dev_mask_o == 2'b10, "R4 device 1 only mask", dev_mask_o, 2);
    chk(!fail_o, "R8 immediate ready", fail_o, 0);
    exp_acc(20, 1, 0, 6, 8'hA0, "R6 reset selects device 0");
    chk(stat_reads() == 1, "R8 single status read", stat_reads(), 1);
  endtask

  task automatic t_none();
    int ctl_w = 0;
    run_seq(2'b00, 0, -1);
    chk(dev_mask_o == 2'b00, "R5 empty mask", dev_mask_o, 0);
    chk(fail_o, "R5 fail flag", fail_o, 1);
    for (int i = 0; i < lg_n; i++) if (lg_wr[i] && lg_sel[i]) ctl_w++;
    chk(ctl_w == 0, "R5 no control writes", ctl_w, 0);
    chk(stat_reads() == 0, "R5 no status reads", stat_reads(), 0);
  endtask

  task automatic t_retry();
    run_seq(2'b01, FIRST_POLLS + 2, -1);
    chk(dev_mask_o == 2'b01, "R4 device 0 only mask", dev_mask_o, 1);
    chk(!fail_o, "R9 recovers in retry round", fail_o, 0);
    chk(stat_reads() == FIRST_POLLS + 3, "R9 read count", stat_reads(), FIRST_POLLS + 3);
    chk(idle_between(25 + FIRST_POLLS - 1, 25 + FIRST_POLLS) >= RETRY_GAP, "R9 round gap",
        idle_between(25 + FIRST_POLLS - 1, 25 + FIRST_POLLS), RETRY_GAP);
    chk(idle_between(25 + FIRST_POLLS + 1, 25 + FIRST_POLLS + 2) >= RETRY_GAP, "R9 second round gap",
        idle_between(25 + FIRST_POLLS + 1, 25 + FIRST_POLLS + 2), RETRY_GAP);
  endtask

  task automatic t_timeout();
    run_seq(2'b01, 1000, -1);
    chk(fail_o, "R10 stuck busy fails", fail_o, 1);
    chk(stat_reads() == FIRST_POLLS + MAX_RETRIES * RETRY_POLLS, "R10 total reads",
        stat_reads(), FIRST_POLLS + MAX_RETRIES * RETRY_POLLS);
    chk(dev_mask_o == 2'b01, "R12 mask kept on failure", dev_mask_o, 1);
  endtask

  task automatic t_start_ignored();
    run_seq(2'b11, 3, 15);
    chk(lg_n == 29, "R11 no repeated sequence", lg_n, 29);
    repeat (200) @(negedge clk);
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);
    chk(lg_n == 29, "R11 no later access", lg_n, 29);
    chk(dev_mask_o == 2'b11 && !fail_o, "R12 results held", int'({fail_o, dev_mask_o}), 3);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    pres = 2'b00;
    busy_init = 0;
    busy_seen = 0;
    cur_dev = 1'b0;
    for (int i = 0; i < 2; i++) begin
      ns_reg[i] = 8'h00;
      lb_reg[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_both_present();
    t_dev1_only();
    t_none();
    t_retry();
    t_timeout();
    t_start_ignored();
    chk(rw_clash == 0, "R13 read and write together", rw_clash, 0);
    chk(done_wide == 0, "R12 done pulse width", done_wide, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule